// File: doc/BRIEF.md
# Data-Phase Timeout Watchdog

This block guards the data phase of a memory-card transfer. When the host expects data, or expects the card to release busy, it pulses an arm input. The block then counts clock cycles. If no done pulse arrives before a programmable limit expires, it raises a sticky timeout error. A 7-bit setting gives the limit as a 4-bit cycle number multiplied by a stepped multiplier. The multiplier is chosen by a 3-bit code and ranges from 1 to 2^20 clock cycles. The longest setting is therefore about 15.7 million cycles.

A prescaler counts up to the selected multiplier and then advances a small counter. That counter holds the cycle number, so no wide multiplier or wide load register is needed. The setting is captured when the block is armed. The sticky error is also placed at bit 22 of a status word that a status register next to this block merges into its own.

The controller has three states.
- IDLE: nothing is being watched.
- RUN: a count is active, and `waiting` is high.
- EXPD: the limit ran out and nothing has been armed since.

The transitions are:
- IDLE→RUN on arm with a non-zero cycle number.
- IDLE→EXPD on arm with cycle number zero.
- RUN→IDLE on done.
- RUN→EXPD on expiry.
- RUN→RUN on a re-arm, which restarts the count.
- EXPD→IDLE on clear.
- EXPD→RUN on arm.

Top module: `data_wait_timer`

## Requirements
- R1: After reset, `tmo_flag`, `waiting` and `stat_word` are all zero.
- R2: `tmo_cfg[3:0]` is the cycle number N. `tmo_cfg[6:4]` is a code that selects the multiplier M: codes 0..7 give 1, 16, 128, 256, 1024, 4096, 65536 and 1048576. Each of these is divided by 2^SCALE_LOG2, with a floor of 1.
- R3: With N ≥ 1, `tmo_flag` rises at exactly the N·M-th rising edge after the edge that samples `arm`. It is still low one edge earlier.
- R4: Arming with N = 0 sets `tmo_flag` at the arming edge itself, and `waiting` stays low.
- R5: `waiting` is high from the arming edge (N ≥ 1) until the edge of expiry or done.
- R6: A `done` pulse before expiry drops `waiting` and no error is raised later.
- R7: A `done` sampled at the same edge as expiry wins, and no error is raised.
- R8: Arming while RUN restarts the count from zero, using the current setting.
- R9: `tmo_cfg` is sampled only at arming. Later changes do not move the expiry edge.
- R10: `tmo_flag` stays set until a `clr` pulse. If expiry and `clr` fall on the same edge, the flag ends set.
- R11: `stat_word` carries `tmo_flag` at bit 22, and every other bit is zero.
- R12: Arming while the flag is set starts a new count without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_cfg | input | 7 | Setting: [3:0] cycle number, [6:4] multiplier code |
| arm | input | 1 | One-cycle strobe: data phase starts, begin counting |
| done | input | 1 | One-cycle strobe: data or not-busy arrived, stop counting |
| clr | input | 1 | One-cycle strobe: status was read, clear the error |
| tmo_flag | output | 1 | Sticky data-timeout error |
| waiting | output | 1 | High while a count is active |
| stat_word | output | 32 | Status contribution, error at bit 22 |

## Verification
The bench builds two instances.
- The first uses SCALE_LOG2 = 0, so multiplier codes 0 to 6 are timed at their true lengths. The longest of these is a 65536-cycle wait.
- The second uses SCALE_LOG2 = 10. This shrinks code 7 to 1024 cycles, so the largest setting (cycle number 15, top code) can be run to its exact expiry edge within the bench's time budget.

Every cycle-sensitive case is placed on the exact edge where the outcome changes:
- stop against expiry on the same edge;
- clear against expiry on the same edge;
- re-arm during a count;
- a setting change after arming.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EXPD = 2'd2
    } dtw_state_e;

    // log2 of the multiplier for a code, reduced by scale, floored at zero
    function automatic logic [4:0] mul_log2(input logic [2:0] code, input int scale);
        int base;
        unique case (code)
            3'd0: base = 0;
            3'd1: base = 4;
            3'd2: base = 7;
            3'd3: base = 8;
            3'd4: base = 10;
            3'd5: base = 12;
            3'd6: base = 16;
            default: base = 20;
        endcase
        base = base - scale;
        if (base < 0) base = 0;
        return 5'(base);
    endfunction

endpackage

// File: rtl/dtw_prescaler.sv
module dtw_prescaler #(
    parameter int PW = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [4:0] shift,
    output logic       tick
);
    logic [PW-1:0] cnt_q;
    logic [PW:0]   span;
    logic [PW-1:0] top;

    always_comb begin
        span = (PW+1)'(1) << shift;
        top  = PW'(span - (PW+1)'(1));
    end

    assign tick = en && (cnt_q == top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (en)      cnt_q <= tick ? '0 : cnt_q + PW'(1);
    end

    // R3: the prescaler never runs past the selected multiplier
    assert_presc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q <= top);

endmodule

// File: rtl/dtw_cycle_counter.sv
module dtw_cycle_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + CW'(1);
    end

    // R2: the cycle count stays below the captured cycle number
    assert_cycles_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && limit != '0) |-> cnt_q < limit);

endmodule

// File: rtl/data_wait_timer.sv
module data_wait_timer
    import dtw_pkg::*;
#(
    parameter int SCALE_LOG2   = 0,
    parameter int MUL_LOG2_MAX = 20,
    parameter int CYC_W        = 4,
    parameter int CODE_W       = 3,
    parameter int STAT_W       = 32,
    parameter int ERR_POS      = 22
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CYC_W+CODE_W-1:0]   tmo_cfg,
    input  logic                      arm,
    input  logic                      done,
    input  logic                      clr,
    output logic                      tmo_flag,
    output logic                      waiting,
    output logic [STAT_W-1:0]         stat_word
);
    localparam int CFG_W = CYC_W + CODE_W;

    dtw_state_e    state_q, state_d;
    logic [CYC_W-1:0] lim_q;
    logic [4:0]       shift_q;
    logic             flag_q, flag_d;

    logic [CYC_W-1:0]  cyc_in;
    logic [CODE_W-1:0] code_in;
    logic [4:0]        shift_in;
    logic              zero_arm;
    logic              tick, last, expire, cnt_clr, in_run;

    assign cyc_in   = tmo_cfg[CYC_W-1:0];
    assign code_in  = tmo_cfg[CFG_W-1:CYC_W];
    assign shift_in = mul_log2(code_in, SCALE_LOG2);
    assign zero_arm = arm && (cyc_in == '0);
    assign in_run   = (state_q == ST_RUN);
    assign cnt_clr  = !in_run || arm || done;
    assign expire   = in_run && tick && last && !arm && !done;

    dtw_prescaler #(.PW(MUL_LOG2_MAX)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (in_run),
        .shift (shift_q),
        .tick  (tick)
    );

    dtw_cycle_counter #(.CW(CYC_W)) cyc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (tick),
        .limit (lim_q),
        .last  (last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lim_q   <= '0;
            shift_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
            if (arm) begin
                lim_q   <= cyc_in;
                shift_q <= shift_in;
            end
        end
    end

    // next state and sticky error
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = zero_arm ? ST_EXPD : ST_RUN;
            end
            ST_RUN: begin
                if (arm)         state_d = zero_arm ? ST_EXPD : ST_RUN;
                else if (done)   state_d = ST_IDLE;
                else if (expire) state_d = ST_EXPD;
            end
            ST_EXPD: begin
                if (arm)      state_d = zero_arm ? ST_EXPD : ST_RUN;
                else if (clr) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase

        if (zero_arm || expire) flag_d = 1'b1;
        else if (clr)           flag_d = 1'b0;
        else                    flag_d = flag_q;
    end

    // outputs
    always_comb begin
        waiting   = in_run;
        tmo_flag  = flag_q;
        stat_word = '0;
        stat_word[ERR_POS] = flag_q;
    end

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !clr) |=> tmo_flag);

    assert_done_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> !waiting);

    assert_arm_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && tmo_cfg[CYC_W-1:0] != '0) |=> waiting);

    assert_zero_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && tmo_cfg[CYC_W-1:0] == '0) |=> (tmo_flag && !waiting));

    assert_no_error_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo_flag && done && !arm) |=> !tmo_flag);

endmodule

// File: tb/data_wait_timer_tb_top.sv
module data_wait_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  tmo_cfg = '0;
    logic        arm = 1'b0, done = 1'b0, clr = 1'b0;
    logic        flag_m, wait_m, flag_s, wait_s;
    logic [31:0] stat_m, stat_s;
    int          n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    data_wait_timer #(.SCALE_LOG2(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmo_cfg(tmo_cfg), .arm(arm), .done(done), .clr(clr),
        .tmo_flag(flag_m), .waiting(wait_m), .stat_word(stat_m));

    data_wait_timer #(.SCALE_LOG2(10)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .tmo_cfg(tmo_cfg), .arm(arm), .done(done), .clr(clr),
        .tmo_flag(flag_s), .waiting(wait_s), .stat_word(stat_s));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mult(input int code, input int scale);
        int tbl[8] = '{1, 16, 128, 256, 1024, 4096, 65536, 1048576};
        int m = tbl[code] >> scale;
        return (m < 1) ? 1 : m;
    endfunction

    task automatic clear_flags();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // leaves the bench just after the arming edge
    task automatic do_arm(input int n, input int code);
        @(negedge clk); tmo_cfg = {3'(code), 4'(n)}; arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flag", flag_m, 0);
        check("R1 waiting", wait_m, 0);
        check("R1 stat", stat_m, 0);
    endtask

    task automatic t_expiry(input int n, input int code, input bit scaled);
        int total;
        total = n * mult(code, scaled ? 10 : 0);
        clear_flags();
        do_arm(n, code);
        repeat (total - 1) @(negedge clk);
        check("R3 early flag", scaled ? flag_s : flag_m, 0);
        check("R5 waiting", scaled ? wait_s : wait_m, 1);
        @(negedge clk);
        check("R2 R3 expiry flag", scaled ? flag_s : flag_m, 1);
        check("R5 waiting drops", scaled ? wait_s : wait_m, 0);
        check("R11 stat bit", scaled ? stat_s : stat_m, 32'h0040_0000);
    endtask

    task automatic t_zero();
        clear_flags();
        do_arm(0, 3);
        check("R4 flag", flag_m, 1);
        check("R4 waiting", wait_m, 0);
    endtask

    task automatic t_stop();
        clear_flags();
        do_arm(4, 1);
        repeat (20) @(negedge clk);
        done = 1'b1; @(negedge clk); done = 1'b0;
        check("R6 waiting", wait_m, 0);
        repeat (100) @(negedge clk);
        check("R6 no flag", flag_m, 0);
    endtask

    task automatic t_stop_same_edge();
        clear_flags();
        @(negedge clk); tmo_cfg = 7'h01; arm = 1'b1;
        @(negedge clk); arm = 1'b0; done = 1'b1;
        @(negedge clk); done = 1'b0;
        check("R7 flag", flag_m, 0);
        check("R7 waiting", wait_m, 0);
        repeat (5) @(negedge clk);
        check("R7 later flag", flag_m, 0);
    endtask

    task automatic t_restart();
        clear_flags();
        do_arm(2, 1);
        repeat (20) @(negedge clk);
        do_arm(2, 1);
        repeat (31) @(negedge clk);
        check("R8 early flag", flag_m, 0);
        @(negedge clk);
        check("R8 flag", flag_m, 1);
    endtask

    task automatic t_cfg_hold();
        clear_flags();
        do_arm(2, 1);
        tmo_cfg = 7'h01;
        repeat (31) @(negedge clk);
        check("R9 early flag", flag_m, 0);
        @(negedge clk);
        check("R9 flag", flag_m, 1);
    endtask

    task automatic t_sticky();
        repeat (50) @(negedge clk);
        check("R10 held", flag_m, 1);
        clear_flags();
        check("R10 cleared", flag_m, 0);
        check("R11 stat cleared", stat_m, 0);
        @(negedge clk); tmo_cfg = 7'h01; arm = 1'b1;
        @(negedge clk); arm = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R10 set wins", flag_m, 1);
    endtask

    task automatic t_rearm();
        @(negedge clk); tmo_cfg = 7'h02; arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        check("R12 waiting", wait_m, 1);
        check("R12 flag kept", flag_m, 1);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R12 cleared in run", flag_m, 0);
        check("R12 still waiting", wait_m, 1);
        @(negedge clk);
        check("R12 new expiry", flag_m, 1);
        check("R12 done waiting", wait_m, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_expiry(15, 0, 0);
        t_expiry(3, 1, 0);
        t_expiry(2, 2, 0);
        t_expiry(1, 3, 0);
        t_expiry(2, 4, 0);
        t_expiry(1, 5, 0);
        t_expiry(1, 6, 0);
        t_expiry(15, 7, 1);
        t_zero();
        t_stop();
        t_stop_same_edge();
        t_restart();
        t_cfg_hold();
        t_sticky();
        t_rearm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule